// File: doc/BRIEF.md
# Stereo ADC Master Serial Port

This block is the output side of a stereo sigma-delta converter when the converter masters the serial link. All of its timing comes from one master clock. From that clock it derives a bit clock, a word clock that runs at the sample rate, and a frame sync. A left and right two's-complement sample pair arrives on parallel inputs with a valid strobe. Both channels are latched at the same instant, when the word clock rises. The left word is then shifted out while the word clock is high and the right word while it is low, on one serial data line.

A clock-mode pin sets the master-clock divisor per word to 256 or 384. A two-bit format select picks one of four layouts:
- 16-bit MSB-first.
- 18-bit MSB-first.
- 18-bit LSB-first right-justified.
- 16-bit MSB-first with half as many bit slots per word.

A style pin chooses between a one-slot pulse frame sync and a level frame sync. With the test input high, the port no longer sends samples. It forwards a raw one-bit modulator stream instead, and the channel is picked by a word clock that an external device drives.

Top module: `adc_serial_master`

## Requirements
- R1: Outside test mode, the word clock period is 256 master-clock cycles when `clk_mode` is 0 and 384 when it is 1, for every format.
- R2: The bit-clock period is P master-clock cycles, where P is 4 (`clk_mode`=0) or 6 (`clk_mode`=1), doubled for format 3. The bit clock is low for the first P/2 cycles of each slot and high for the rest. There are 64 bit-clock rising edges per word-clock period (32 in format 3). Serial data changes only on a bit-clock falling edge.
- R3: Slots are numbered from 0 at the word-clock rising edge. The word clock is high for the first half of the slots (left) and low for the second half (right), and it changes only on a bit-clock falling edge.
- R4: Format 0 (16-bit) and format 1 (18-bit) are MSB-first. For in-half slot k = 1..W, the data is word bit W-k. A 16-bit word is input bits 17:2 of the 18-bit sample.
- R5: Format 2 is 18-bit LSB-first and right-justified in a 32-slot half. For in-half slot k = 14..31, the data is word bit k-14, so the MSB falls in the last slot before the word-clock edge.
- R6: Format 3 has 16 slots per half. For k = 0..15, the data is input bit 17-k.
- R7: In every slot outside the valid-data window, the serial data is 0.
- R8: With `fs_level`=1, the frame sync is high exactly in the valid-data slots. With `fs_level`=0, it is high only in the one slot just before each channel's first valid slot (in format 3, the last slot of the preceding half) and low elsewhere.
- R9: A pair presented with `sample_valid` during word period n is sent in period n+1, with both channels taken at the same word-clock rising edge. If no new pair arrives, the previous pair is sent again.
- R10: While reset is asserted, the bit clock, word clock, data and frame sync are all 0. After reset is released, the first word-clock rise appears on master-clock rising edge P+2, counting the first edge after release as 1.
- R11: With `test_en`=1, `word_clk_oe` is 0 and the frame sync is 0. On each edge where `mod_stb` is sampled high, the data output takes `mod_left` if `word_clk_i` is 1 and `mod_right` if it is 0, and the bit clock goes low. The bit clock goes back high on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_mode | input | 1 | 0: 256 master clocks per word, 1: 384 |
| fmt_sel | input | 2 | Word layout, 0..3 as in R4 to R6 |
| fs_level | input | 1 | 1: level frame sync, 0: pulse frame sync |
| test_en | input | 1 | Modulator pass-through mode |
| sample_valid | input | 1 | Strobe for a new left/right pair |
| left_in | input | 18 | Left sample, two's complement |
| right_in | input | 18 | Right sample, two's complement |
| mod_stb | input | 1 | One pulse per modulator output bit |
| mod_left | input | 1 | Left modulator bit |
| mod_right | input | 1 | Right modulator bit |
| word_clk_i | input | 1 | Channel select in test mode (1 = left) |
| bit_clk_o | output | 1 | Bit clock |
| word_clk_o | output | 1 | Word clock in normal mode |
| word_clk_oe | output | 1 | Word clock output enable (0 in test mode) |
| sdata_o | output | 1 | Serial data |
| fsync_o | output | 1 | Frame sync |

## Verification
The word clock, the slot's data bit and the frame sync all update on the same master edge, the one that ends a slot. The bit clock rises P/2 cycles after that edge. The bench reads every output on the falling master edge, and it records data, frame sync and word clock at each observed bit-clock rise. Each value is therefore taken mid-slot and indexed by slot count from the last word-clock rise. Startup is counted in master edges from reset release and is due at edge P+2. A new pair is due in the word period after the one in which it was strobed. In test mode the data and bit clock are due one edge after `mod_stb`, and the bit clock returns high one edge later.

// File: rtl/adcsp_pkg.sv
package adcsp_pkg;

  typedef enum logic [1:0] {
    FMT_MSB_STD  = 2'd0,
    FMT_MSB_WIDE = 2'd1,
    FMT_LSB_WIDE = 2'd2,
    FMT_MSB_HALF = 2'd3
  } fmt_e;

  // Slots in one channel half for a layout.
  function automatic int half_slots(fmt_e f, int full);
    return (f == FMT_MSB_HALF) ? full / 4 : full / 2;
  endfunction

  // Word length carried by a layout.
  function automatic int word_len(fmt_e f, int wide, int narrow);
    return (f == FMT_MSB_STD || f == FMT_MSB_HALF) ? narrow : wide;
  endfunction

  // Position of a slot inside its channel's valid window (may be out of range).
  function automatic int win_pos(fmt_e f, int slot, int full, int wide);
    int h;
    int k0;
    h = half_slots(f, full);
    if (f == FMT_LSB_WIDE)      k0 = h - wide;
    else if (f == FMT_MSB_HALF) k0 = 0;
    else                        k0 = 1;
    return (slot % h) - k0;
  endfunction

endpackage

// File: rtl/adcsp_clkgen.sv
module adcsp_clkgen #(
  parameter int FULL_SLOTS = 64,
  parameter int DIV_LO     = 4,
  parameter int DIV_HI     = 6,
  parameter int SLOT_W     = $clog2(FULL_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              cmode,
  input  logic              half_rate,
  output logic              tick,
  output logic              wrap,
  output logic [SLOT_W-1:0] slot_nxt,
  output logic              bclk,
  output logic              lrck
);

  localparam int PH_W = $clog2(2 * DIV_HI + 1);

  logic [PH_W-1:0]   ph_q, ph_d;
  logic [PH_W-1:0]   base_div, period, half_per;
  logic [SLOT_W-1:0] slot_q, slot_d, slot_inc;
  logic [SLOT_W:0]   n_slots;
  logic              bclk_q, bclk_d;
  logic              lrck_q, lrck_d;
  logic              end_of_slot;

  always_comb begin
    base_div = cmode ? PH_W'(DIV_HI) : PH_W'(DIV_LO);
    period   = half_rate ? (base_div << 1) : base_div;
    half_per = period >> 1;
    n_slots  = half_rate ? (SLOT_W+1)'(FULL_SLOTS / 2) : (SLOT_W+1)'(FULL_SLOTS);
    end_of_slot = (ph_q == period - PH_W'(1));
    if ({1'b0, slot_q} >= n_slots - (SLOT_W+1)'(1)) slot_inc = '0;
    else                                            slot_inc = slot_q + SLOT_W'(1);
  end

  // next state
  always_comb begin
    ph_d   = ph_q;
    slot_d = slot_q;
    bclk_d = bclk_q;
    lrck_d = lrck_q;
    if (hold) begin
      ph_d   = '0;
      slot_d = '1;
      bclk_d = 1'b0;
      lrck_d = 1'b0;
    end else if (end_of_slot) begin
      ph_d   = '0;
      slot_d = slot_inc;
      bclk_d = 1'b0;
      lrck_d = ({1'b0, slot_inc} < (n_slots >> 1));
    end else begin
      ph_d = ph_q + PH_W'(1);
      if (ph_q == half_per - PH_W'(1)) bclk_d = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      slot_q <= '1;
      bclk_q <= 1'b0;
      lrck_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      slot_q <= slot_d;
      bclk_q <= bclk_d;
      lrck_q <= lrck_d;
    end
  end

  assign tick     = end_of_slot && !hold;
  assign wrap     = tick && (slot_inc == '0);
  assign slot_nxt = slot_inc;
  assign bclk     = bclk_q;
  assign lrck     = lrck_q;

endmodule

// File: rtl/adcsp_slot_map.sv
module adcsp_slot_map
  import adcsp_pkg::*;
#(
  parameter int SAMPLE_W   = 18,
  parameter int NARROW_W   = 16,
  parameter int FULL_SLOTS = 64,
  parameter int SLOT_W     = $clog2(FULL_SLOTS),
  parameter int IDX_W      = $clog2(SAMPLE_W)
) (
  input  fmt_e              fmt,
  input  logic [SLOT_W-1:0] slot,
  output logic              in_win,
  output logic              is_right,
  output logic              ahead_first,
  output logic [IDX_W-1:0]  sidx
);

  int hs, wl, pos, bit_n, nxt, pos_n;

  always_comb begin
    hs       = half_slots(fmt, FULL_SLOTS);
    wl       = word_len(fmt, SAMPLE_W, NARROW_W);
    pos      = win_pos(fmt, int'(slot), FULL_SLOTS, SAMPLE_W);
    in_win   = (pos >= 0) && (pos < wl);
    is_right = (int'(slot) >= hs);
    bit_n    = (fmt == FMT_LSB_WIDE) ? pos : (wl - 1 - pos);
    sidx     = in_win ? IDX_W'(SAMPLE_W - wl + bit_n) : '0;
    // lookahead one slot for the pulse-style frame sync
    nxt         = (int'(slot) + 1) % (2 * hs);
    pos_n       = win_pos(fmt, nxt, FULL_SLOTS, SAMPLE_W);
    ahead_first = (pos_n == 0);
  end

endmodule

// File: rtl/adcsp_shifter.sv
module adcsp_shifter #(
  parameter int SAMPLE_W = 18,
  parameter int IDX_W    = $clog2(SAMPLE_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                test_en,
  input  logic                fs_level,
  input  logic                sample_valid,
  input  logic [SAMPLE_W-1:0] left_in,
  input  logic [SAMPLE_W-1:0] right_in,
  input  logic                tick,
  input  logic                wrap,
  input  logic                in_win,
  input  logic                is_right,
  input  logic                ahead_first,
  input  logic [IDX_W-1:0]    sidx,
  input  logic                mod_stb,
  input  logic                mod_left,
  input  logic                mod_right,
  input  logic                lr_sel,
  output logic                sdata,
  output logic                fsync,
  output logic                test_bclk
);

  // index 0 = left, 1 = right
  logic [1:0][SAMPLE_W-1:0] pend_q, pend_d, shad_q, shad_d;
  logic [SAMPLE_W-1:0]      word_sel;
  logic                     sdata_q, sdata_d, fs_q, fs_d, tbclk_q, tbclk_d;

  always_comb begin
    pend_d = pend_q;
    shad_d = shad_q;
    if (sample_valid) pend_d = {right_in, left_in};
    if (wrap)         shad_d = pend_q;
  end

  always_comb begin
    sdata_d  = sdata_q;
    fs_d     = fs_q;
    tbclk_d  = 1'b0;
    word_sel = wrap ? pend_q[is_right] : shad_q[is_right];
    if (test_en) begin
      fs_d = 1'b0;
      if (mod_stb) begin
        sdata_d = lr_sel ? mod_left : mod_right;
        tbclk_d = 1'b0;
      end else begin
        tbclk_d = 1'b1;
      end
    end else if (tick) begin
      sdata_d = in_win ? word_sel[sidx] : 1'b0;
      fs_d    = fs_level ? in_win : ahead_first;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      shad_q  <= '0;
      sdata_q <= 1'b0;
      fs_q    <= 1'b0;
      tbclk_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      shad_q  <= shad_d;
      sdata_q <= sdata_d;
      fs_q    <= fs_d;
      tbclk_q <= tbclk_d;
    end
  end

  assign sdata     = sdata_q;
  assign fsync     = fs_q;
  assign test_bclk = tbclk_q;

endmodule

// File: rtl/adc_serial_master.sv
module adc_serial_master
  import adcsp_pkg::*;
#(
  parameter int SAMPLE_W   = 18,
  parameter int NARROW_W   = 16,
  parameter int FULL_SLOTS = 64,
  parameter int DIV_LO     = 4,
  parameter int DIV_HI     = 6
) (
  input  logic                mclk,
  input  logic                rst_n,
  input  logic                clk_mode,
  input  logic [1:0]          fmt_sel,
  input  logic                fs_level,
  input  logic                test_en,
  input  logic                sample_valid,
  input  logic [SAMPLE_W-1:0] left_in,
  input  logic [SAMPLE_W-1:0] right_in,
  input  logic                mod_stb,
  input  logic                mod_left,
  input  logic                mod_right,
  input  logic                word_clk_i,
  output logic                bit_clk_o,
  output logic                word_clk_o,
  output logic                word_clk_oe,
  output logic                sdata_o,
  output logic                fsync_o
);

  localparam int SLOT_W = $clog2(FULL_SLOTS);
  localparam int IDX_W  = $clog2(SAMPLE_W);

  fmt_e              fmt;
  logic [1:0]        rst_sync_q;
  logic              rs_n;
  logic              tick, wrap, gen_bclk, gen_lrck, test_bclk;
  logic [SLOT_W-1:0] slot_nxt;
  logic              in_win, is_right, ahead_first;
  logic [IDX_W-1:0]  sidx;

  // asynchronous assert, synchronous release
  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rs_n = rst_sync_q[1];

  assign fmt = fmt_e'(fmt_sel);

  adcsp_clkgen #(
    .FULL_SLOTS(FULL_SLOTS), .DIV_LO(DIV_LO), .DIV_HI(DIV_HI), .SLOT_W(SLOT_W)
  ) i_clkgen (
    .clk       (mclk),
    .rst_n     (rs_n),
    .hold      (test_en),
    .cmode     (clk_mode),
    .half_rate (fmt == FMT_MSB_HALF),
    .tick      (tick),
    .wrap      (wrap),
    .slot_nxt  (slot_nxt),
    .bclk      (gen_bclk),
    .lrck      (gen_lrck)
  );

  adcsp_slot_map #(
    .SAMPLE_W(SAMPLE_W), .NARROW_W(NARROW_W), .FULL_SLOTS(FULL_SLOTS),
    .SLOT_W(SLOT_W), .IDX_W(IDX_W)
  ) i_map (
    .fmt         (fmt),
    .slot        (slot_nxt),
    .in_win      (in_win),
    .is_right    (is_right),
    .ahead_first (ahead_first),
    .sidx        (sidx)
  );

  adcsp_shifter #(
    .SAMPLE_W(SAMPLE_W), .IDX_W(IDX_W)
  ) i_shifter (
    .clk          (mclk),
    .rst_n        (rs_n),
    .test_en      (test_en),
    .fs_level     (fs_level),
    .sample_valid (sample_valid),
    .left_in      (left_in),
    .right_in     (right_in),
    .tick         (tick),
    .wrap         (wrap),
    .in_win       (in_win),
    .is_right     (is_right),
    .ahead_first  (ahead_first),
    .sidx         (sidx),
    .mod_stb      (mod_stb),
    .mod_left     (mod_left),
    .mod_right    (mod_right),
    .lr_sel       (word_clk_i),
    .sdata        (sdata_o),
    .fsync        (fsync_o),
    .test_bclk    (test_bclk)
  );

  assign bit_clk_o   = test_en ? test_bclk : gen_bclk;
  assign word_clk_o  = gen_lrck;
  assign word_clk_oe = !test_en;

endmodule

// File: rtl/adcsp_checker.sv
module adcsp_checker (
  input logic clk,
  input logic rst_n,
  input logic test_en,
  input logic fs_level,
  input logic mod_stb,
  input logic mod_left,
  input logic mod_right,
  input logic word_clk_i,
  input logic bit_clk_o,
  input logic word_clk_o,
  input logic sdata_o,
  input logic fsync_o
);

  // Format and frame-sync style are static outside reset.

  assert_lrck_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_en && !$past(test_en) && !$stable(word_clk_o)) |-> $fell(bit_clk_o));

  assert_data_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_en && !$past(test_en) && !$stable(sdata_o)) |-> $fell(bit_clk_o));

  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_level && !test_en && !$past(test_en) && !fsync_o) |-> !sdata_o);

  assert_test_fs_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && $past(test_en)) |-> !fsync_o);

  assert_test_route_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && $past(test_en) && $past(mod_stb)) |->
      (!bit_clk_o && (sdata_o == ($past(word_clk_i) ? $past(mod_left) : $past(mod_right)))));

endmodule

bind adc_serial_master adcsp_checker i_adcsp_checker (
  .clk        (mclk),
  .rst_n      (rst_n),
  .test_en    (test_en),
  .fs_level   (fs_level),
  .mod_stb    (mod_stb),
  .mod_left   (mod_left),
  .mod_right  (mod_right),
  .word_clk_i (word_clk_i),
  .bit_clk_o  (bit_clk_o),
  .word_clk_o (word_clk_o),
  .sdata_o    (sdata_o),
  .fsync_o    (fsync_o)
);

// File: tb/test_adc_serial_master.sv
module test_adc_serial_master;

  logic        mclk = 1'b0;
  logic        rst_n, clk_mode, fs_level, test_en, sample_valid;
  logic [1:0]  fmt_sel;
  logic [17:0] left_in, right_in;
  logic        mod_stb, mod_left, mod_right, word_clk_i;
  logic        bit_clk_o, word_clk_o, word_clk_oe, sdata_o, fsync_o;

  int checks = 0;
  int errors = 0;

  logic cap_lr [64];
  logic cap_d  [64];
  logic cap_fs [64];
  int   cap_n, cap_cycles, bad_per;

  always #2 mclk = ~mclk;

  adc_serial_master i_adc_serial_master (
    .mclk(mclk), .rst_n(rst_n), .clk_mode(clk_mode), .fmt_sel(fmt_sel),
    .fs_level(fs_level), .test_en(test_en), .sample_valid(sample_valid),
    .left_in(left_in), .right_in(right_in), .mod_stb(mod_stb),
    .mod_left(mod_left), .mod_right(mod_right), .word_clk_i(word_clk_i),
    .bit_clk_o(bit_clk_o), .word_clk_o(word_clk_o), .word_clk_oe(word_clk_oe),
    .sdata_o(sdata_o), .fsync_o(fsync_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected slot content from the requirements.
  function automatic void model(input int fmt, input int s, input logic [17:0] l, input logic [17:0] r,
                                output bit v, output bit d, output bit ff);
    int h, wl, k0, pos, b, nx, pn;
    logic [17:0] w;
    h  = (fmt == 3) ? 16 : 32;
    wl = (fmt == 0 || fmt == 3) ? 16 : 18;
    k0 = (fmt == 2) ? h - 18 : ((fmt == 3) ? 0 : 1);
    pos = (s % h) - k0;
    v = (pos >= 0) && (pos < wl);
    b = (fmt == 2) ? pos : (wl - 1 - pos);
    w = (s < h) ? l : r;
    d = v ? w[18 - wl + b] : 1'b0;
    nx = (s + 1) % (2 * h);
    pn = (nx % h) - k0;
    ff = (pn == 0);
  endfunction

  task automatic capture_frame(input bit send, input logic [17:0] nl, input logic [17:0] nr, input int per);
    logic prev_b, prev_lr;
    int last_rise;
    cap_n = 0; cap_cycles = 0; bad_per = 0; last_rise = -1;
    prev_b = bit_clk_o; prev_lr = word_clk_o;
    while (cap_cycles < 1000) begin
      @(posedge mclk);
      @(negedge mclk);
      cap_cycles++;
      sample_valid = send && (cap_cycles == 20);
      if (send && cap_cycles == 20) begin
        left_in = nl; right_in = nr;
      end
      if (bit_clk_o && !prev_b) begin
        if (cap_n < 64) begin
          cap_lr[cap_n] = word_clk_o; cap_d[cap_n] = sdata_o; cap_fs[cap_n] = fsync_o;
        end
        if (last_rise >= 0 && (cap_cycles - last_rise) != per) bad_per++;
        last_rise = cap_cycles;
        cap_n++;
      end
      if (word_clk_o && !prev_lr) break;
      prev_b = bit_clk_o; prev_lr = word_clk_o;
    end
    sample_valid = 1'b0;
  endtask

  task automatic verify(input int cm, input int fmt, input bit fl, input logic [17:0] l,
                        input logic [17:0] r, input bit is_r9);
    int slots;
    string dtag;
    bit v, d, ff, efs;
    slots = (fmt == 3) ? 32 : 64;
    chk(cap_cycles == (cm ? 384 : 256), "R1 word period", cap_cycles, cm ? 384 : 256);
    chk(cap_n == slots, "R2 bit clocks per word", cap_n, slots);
    chk(bad_per == 0, "R2 bit clock period", bad_per, 0);
    for (int s = 0; s < slots && s < cap_n; s++) begin
      model(fmt, s, l, r, v, d, ff);
      efs = fl ? v : ff;
      chk(cap_lr[s] == (s < slots / 2), "R3 word clock level", int'(cap_lr[s]), int'(s < slots / 2));
      if (!v)             dtag = "R7 idle slot";
      else if (is_r9)     dtag = "R9 sample pair";
      else if (fmt == 2)  dtag = "R5 lsb-first data";
      else if (fmt == 3)  dtag = "R6 half-rate data";
      else                dtag = "R4 msb-first data";
      chk(cap_d[s] == d, dtag, int'(cap_d[s]), int'(d));
      chk(cap_fs[s] == efs, "R8 frame sync", int'(cap_fs[s]), int'(efs));
    end
  endtask

  task automatic run_cfg(input int cm, input int fmt, input bit fl, input int idx);
    logic [17:0] al, ar, bl, br;
    int per, n;
    al = 18'h20001 + 18'(idx * 18'h1357);
    ar = 18'h1FFFE - 18'(idx * 18'h0B3D);
    bl = ~ar;
    br = al ^ 18'h15A5A;
    per = (cm ? 6 : 4) * ((fmt == 3) ? 2 : 1);
    rst_n = 1'b0; test_en = 1'b0; sample_valid = 1'b0;
    clk_mode = cm[0]; fmt_sel = fmt[1:0]; fs_level = fl;
    repeat (3) @(posedge mclk);
    @(negedge mclk);
    chk({bit_clk_o, word_clk_o, sdata_o, fsync_o} == 4'b0, "R10 reset outputs",
        int'({bit_clk_o, word_clk_o, sdata_o, fsync_o}), 0);
    rst_n = 1'b1;
    n = 0;
    while (n < 100) begin
      @(posedge mclk);
      @(negedge mclk);
      n++;
      sample_valid = (n == 3);
      if (n == 3) begin
        left_in = al; right_in = ar;
      end
      if (word_clk_o) break;
    end
    sample_valid = 1'b0;
    chk(n == per + 2, "R10 first word clock rise", n, per + 2);
    capture_frame(1'b1, bl, br, per);
    verify(cm, fmt, fl, al, ar, 1'b0);
    capture_frame(1'b0, 18'h0, 18'h0, per);
    verify(cm, fmt, fl, bl, br, 1'b1);
    capture_frame(1'b0, 18'h0, 18'h0, per);
    verify(cm, fmt, fl, bl, br, 1'b1);
  endtask

  task automatic run_test_mode();
    rst_n = 1'b0; test_en = 1'b1; mod_stb = 1'b0;
    repeat (3) @(posedge mclk);
    @(negedge mclk);
    rst_n = 1'b1;
    repeat (4) @(posedge mclk);
    @(negedge mclk);
    for (int i = 0; i < 8; i++) begin
      word_clk_i = i[0]; mod_left = i[1]; mod_right = i[2];
      mod_stb = 1'b1;
      @(posedge mclk);
      @(negedge mclk);
      mod_stb = 1'b0;
      chk(sdata_o == (i[0] ? i[1] : i[2]), "R11 test data route", int'(sdata_o), int'(i[0] ? i[1] : i[2]));
      chk(bit_clk_o == 1'b0, "R11 test bit clock low", int'(bit_clk_o), 0);
      chk(!fsync_o && !word_clk_oe, "R11 test fs and oe", int'({fsync_o, word_clk_oe}), 0);
      @(posedge mclk);
      @(negedge mclk);
      chk(bit_clk_o == 1'b1, "R11 test bit clock high", int'(bit_clk_o), 1);
      @(posedge mclk);
      @(negedge mclk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge mclk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clk_mode = 1'b0; fmt_sel = 2'd0; fs_level = 1'b0; test_en = 1'b0;
    sample_valid = 1'b0; left_in = '0; right_in = '0;
    mod_stb = 1'b0; mod_left = 1'b0; mod_right = 1'b0; word_clk_i = 1'b0;
    for (int cm = 0; cm < 2; cm++)
      for (int fmt = 0; fmt < 4; fmt++)
        for (int fl = 0; fl < 2; fl++)
          run_cfg(cm, fmt, fl[0], cm * 8 + fmt * 2 + fl);
    run_test_mode();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule